// File: doc/BRIEF.md
# Serial Port with In-Word Parity

This block is a full-duplex asynchronous serial transmitter and receiver behind a three-register word bus. Software configures it through a control register, watches a status register, and moves characters through a single data address. A write to that address fills a transmit holding register. A read of the same address returns a separate receive holding register. Each character is 8 or 9 bits long and is sent least significant bit first. A frame is one low start bit, the character bits, and one high stop bit. A fixed divider produces the bit timing: one bit lasts 16 oversampling ticks, and one tick lasts `CLK_DIV` clocks.

When parity is enabled, it does not add a bit to the frame. The most significant bit of the configured character length carries the parity instead: bit 7 for 8-bit characters, bit 8 for 9-bit characters. On transmit, the hardware replaces whatever software wrote in that position. On receive, the parity bit as it arrived is returned in that position. A failed parity check sets a sticky error flag. The flag raises an interrupt when its enable bit is set. Software clears the flag with a status read followed by a data read, with no other bus access between the two.

Top module: `uart_wordpar`

## Requirements
- R1: After reset, status reads 0x4 (transmit holding empty), control reads 0, `irq` is 0 and `tx_out` is 1.
- R2: A read at address 1 returns the receive holding register in bits [8:0] with bits [31:9] zero. The read clears the receive-full status bit (status bit 1).
- R3: Control bit 0 enables transmit. Once it is set, a write at address 1 clears status bit 2. The character then leaves on `tx_out` as a 0 start bit, the character bits LSB first, and a 1 stop bit, each lasting 16*`CLK_DIV` clocks. Status bit 2 sets again when the shifter takes the character.
- R4: Control bit 1 enables receive. With control bit 2 at 0 (8-bit) and parity off, every 8-bit value looped from `tx_out` to `rx_in` reads back unchanged, and status bit 0 stays 0.
- R5: With control bit 2 at 1 (9-bit) and parity off, 9-bit values loop back unchanged.
- R6: With control bit 3 set (parity on), the written value of the top bit is ignored on transmit. The bit is replaced by the parity of the lower bits, with control bit 4 = 0 for even and 1 for odd. Even parity gives an even count of ones over the whole character; odd parity gives an odd count.
- R7: With parity on, a received character reads back with its received parity bit in the top bit position.
- R8: A received character that fails the parity check sets status bit 0 in the cycle the character completes, together with status bit 1, at the middle of the stop bit. A passing character leaves status bit 0 unchanged.
- R9: Status bit 0 is cleared by a data read whose most recent preceding bus access was a status read made while bit 0 was set.
- R10: A data read that does not follow a status read, or that follows one with another bus access in between, leaves status bit 0 set.
- R11: `irq` is high exactly while status bit 0 and control bit 5 (parity interrupt enable) are both 1.
- R12: A low pulse on `rx_in` that lasts less than half a bit time does not start a reception.
- R13: While control bit 0 is 0, a written character stays in the holding register, status bit 2 stays 0 and `tx_out` stays 1. The character is sent once bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 = status, 1 = data, 2 = control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Parity error interrupt |
| tx_out | output | 1 | Serial transmit line, idle high |
| rx_in | input | 1 | Serial receive line, idle high |

## Verification
The assertions take these conditions for granted:
- Software writes the data address only while the transmit-empty bit is set.
- The configuration does not change while a frame is on either line.
- Each received character is read before the next one completes, so no receive overrun occurs.

The bench keeps to these conditions in three ways:
- It polls status bit 2 before every write.
- It reprograms control only with both lines idle.
- It drains the data register after every frame, including injected frames whose parity bit is deliberately wrong and the rejected start glitch.

// File: rtl/uart_wordpar_pkg.sv
package uart_wordpar_pkg;

    localparam int WORD_W = 9;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;
    localparam int OVS    = 16;
    localparam int SUB_W  = $clog2(OVS);
    localparam int CNT_W  = 4;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

    typedef struct packed {
        logic perr_ie;
        logic par_odd;
        logic par_en;
        logic wlen9;
        logic rx_en;
        logic tx_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic perr;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    typedef struct packed {
        logic              valid;
        logic              bad_par;
        logic [WORD_W-1:0] word;
    } rx_result_t;

    function automatic logic [CNT_W-1:0] word_len(input logic wlen9);
        return wlen9 ? CNT_W'(9) : CNT_W'(8);
    endfunction

    function automatic logic [WORD_W-1:0] tx_word(input logic [WORD_W-1:0] data,
                                                  input logic wlen9,
                                                  input logic par_en,
                                                  input logic par_odd);
        logic [WORD_W-1:0] w;
        w = wlen9 ? data : {1'b0, data[7:0]};
        if (par_en) begin
            if (wlen9) w[8] = (^w[7:0]) ^ par_odd;
            else       w[7] = (^w[6:0]) ^ par_odd;
        end
        return w;
    endfunction

    function automatic logic parity_bad(input logic [WORD_W-1:0] word,
                                        input logic par_en,
                                        input logic par_odd);
        return par_en && ((^word) != par_odd);
    endfunction

endpackage

// File: rtl/uart_wordpar_tick.sv
module uart_wordpar_tick #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/uart_wordpar_tx.sv
module uart_wordpar_tx
    import uart_wordpar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              wlen9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_word,
    output logic              take,
    output logic              tx_out
);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(OVS - 1);

    tx_state_e         st_q;
    logic [SUB_W-1:0]  sub_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  nbits_q;
    logic [WORD_W-1:0] sh_q;
    logic              line_q;

    assign take   = tick && (st_q == TX_IDLE) && hold_full && tx_en;
    assign tx_out = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= TX_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
            nbits_q <= CNT_W'(8);
            sh_q    <= '0;
            line_q  <= 1'b1;
        end else if (tick) begin
            if (st_q == TX_IDLE) begin
                if (hold_full && tx_en) begin
                    sh_q    <= tx_word(hold_word, wlen9, par_en, par_odd);
                    nbits_q <= word_len(wlen9);
                    sub_q   <= '0;
                    line_q  <= 1'b0;
                    st_q    <= TX_START;
                end
            end else if (sub_q != LAST_SUB) begin
                sub_q <= sub_q + 1'b1;
            end else begin
                sub_q <= '0;
                unique case (st_q)
                    TX_START: begin
                        st_q   <= TX_DATA;
                        idx_q  <= '0;
                        line_q <= sh_q[0];
                        sh_q   <= sh_q >> 1;
                    end
                    TX_DATA: begin
                        if (idx_q == nbits_q - 1'b1) begin
                            st_q   <= TX_STOP;
                            line_q <= 1'b1;
                        end else begin
                            idx_q  <= idx_q + 1'b1;
                            line_q <= sh_q[0];
                            sh_q   <= sh_q >> 1;
                        end
                    end
                    default: st_q <= TX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_wordpar_rx.sv
module uart_wordpar_rx
    import uart_wordpar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_en,
    input  logic       wlen9,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rx_in,
    output rx_result_t res
);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] MID_SUB  = SUB_W'(OVS / 2 - 1);

    logic [1:0]        sync_q;
    logic              bit_now;
    rx_state_e         st_q;
    logic [SUB_W-1:0]  sub_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  nbits_q;
    logic [WORD_W-1:0] word_q;

    assign bit_now = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rx_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= RX_IDLE;
            sub_q     <= '0;
            idx_q     <= '0;
            nbits_q   <= CNT_W'(8);
            word_q    <= '0;
            res       <= '0;
        end else begin
            res.valid <= 1'b0;
            if (tick) begin
                unique case (st_q)
                    RX_IDLE: begin
                        if (rx_en && !bit_now) begin
                            st_q  <= RX_START;
                            sub_q <= '0;
                        end
                    end
                    RX_START: begin
                        if (sub_q == MID_SUB) begin
                            sub_q <= '0;
                            if (!bit_now) begin
                                st_q    <= RX_DATA;
                                idx_q   <= '0;
                                word_q  <= '0;
                                nbits_q <= word_len(wlen9);
                            end else begin
                                st_q <= RX_IDLE;
                            end
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (sub_q == LAST_SUB) begin
                            sub_q         <= '0;
                            word_q[idx_q] <= bit_now;
                            if (idx_q == nbits_q - 1'b1) st_q <= RX_STOP;
                            else                         idx_q <= idx_q + 1'b1;
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                    default: begin
                        if (sub_q == LAST_SUB) begin
                            sub_q       <= '0;
                            st_q        <= RX_IDLE;
                            res.valid   <= 1'b1;
                            res.word    <= word_q;
                            res.bad_par <= parity_bad(word_q, par_en, par_odd);
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_wordpar_regs.sv
module uart_wordpar_regs
    import uart_wordpar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tx_take,
    input  rx_result_t        rx_res,
    output cfg_t              cfg,
    output stat_t             stat,
    output logic [WORD_W-1:0] tx_hold,
    output logic              irq
);
    logic              rd, wr, rd_stat, rd_data, wr_data, wr_ctrl;
    logic              tx_empty_q, rx_full_q, perr_q, armed_q;
    logic [WORD_W-1:0] rx_hold_q;
    cfg_t              cfg_q;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[BUS_W-1:WORD_W];

    assign rd      = bus_req && !bus_wr;
    assign wr      = bus_req && bus_wr;
    assign rd_stat = rd && (bus_addr == A_STAT);
    assign rd_data = rd && (bus_addr == A_DATA);
    assign wr_data = wr && (bus_addr == A_DATA);
    assign wr_ctrl = wr && (bus_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            tx_hold    <= '0;
            tx_empty_q <= 1'b1;
            rx_hold_q  <= '0;
            rx_full_q  <= 1'b0;
            perr_q     <= 1'b0;
            armed_q    <= 1'b0;
        end else begin
            if (wr_ctrl) cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);

            if (wr_data) begin
                tx_hold    <= bus_wdata[WORD_W-1:0];
                tx_empty_q <= 1'b0;
            end else if (tx_take) begin
                tx_empty_q <= 1'b1;
            end

            if (rx_res.valid) begin
                rx_hold_q <= rx_res.word;
                rx_full_q <= 1'b1;
            end else if (rd_data) begin
                rx_full_q <= 1'b0;
            end

            if (rx_res.valid && rx_res.bad_par) perr_q <= 1'b1;
            else if (rd_data && armed_q)        perr_q <= 1'b0;

            if (bus_req) armed_q <= rd_stat && perr_q;
        end
    end

    assign cfg  = cfg_q;
    assign stat = '{tx_empty: tx_empty_q, rx_full: rx_full_q, perr: perr_q};
    assign irq  = perr_q && cfg_q.perr_ie;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STAT:  bus_rdata[STAT_W-1:0] = stat;
            A_DATA:  bus_rdata[WORD_W-1:0] = rx_hold_q;
            A_CTRL:  bus_rdata[CFG_W-1:0]  = cfg_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_wordpar.sv
module uart_wordpar
    import uart_wordpar_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        tx_out,
    input  logic        rx_in
);
    logic              tick;
    logic              tx_take;
    logic [WORD_W-1:0] tx_hold;
    rx_result_t        rx_res;
    cfg_t              cfg;
    stat_t             stat;

    uart_wordpar_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    uart_wordpar_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_req  (bus_req),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .tx_take  (tx_take),
        .rx_res   (rx_res),
        .cfg      (cfg),
        .stat     (stat),
        .tx_hold  (tx_hold),
        .irq      (irq)
    );

    uart_wordpar_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .tx_en    (cfg.tx_en),
        .wlen9    (cfg.wlen9),
        .par_en   (cfg.par_en),
        .par_odd  (cfg.par_odd),
        .hold_full(!stat.tx_empty),
        .hold_word(tx_hold),
        .take     (tx_take),
        .tx_out   (tx_out)
    );

    uart_wordpar_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rx_en  (cfg.rx_en),
        .wlen9  (cfg.wlen9),
        .par_en (cfg.par_en),
        .par_odd(cfg.par_odd),
        .rx_in  (rx_in),
        .res    (rx_res)
    );
endmodule

// File: rtl/uart_wordpar_chk.sv
module uart_wordpar_chk
    import uart_wordpar_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        irq,
    input logic        tx_out,
    input logic        perr,
    input logic        rx_full,
    input logic        tx_empty,
    input logic        tx_en,
    input logic        irq_en
);
    AST_LINE_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> tx_out); // R1

    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wr && bus_addr == A_DATA) |-> (bus_rdata[31:WORD_W] == '0)); // R2

    AST_TAKE_STARTS_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> !tx_out); // R3

    AST_PERR_WITH_RXNE: assert property (@(posedge clk) disable iff (rst)
        $rose(perr) |-> rx_full); // R8

    AST_PERR_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(perr) |-> $past(bus_req && !bus_wr && bus_addr == A_DATA)); // R9

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($rose(perr) || $rose(irq_en))); // R11

    AST_TX_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !tx_empty) |=> !tx_empty); // R13
endmodule

bind uart_wordpar uart_wordpar_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .tx_out   (tx_out),
    .perr     (stat.perr),
    .rx_full  (stat.rx_full),
    .tx_empty (stat.tx_empty),
    .tx_en    (cfg.tx_en),
    .irq_en   (cfg.perr_ie)
);

// File: tb/uart_wordpar_test.sv
module uart_wordpar_test;
    localparam logic [1:0] AS = 2'd0;
    localparam logic [1:0] AD = 2'd1;
    localparam logic [1:0] AC = 2'd2;
    localparam int BITC  = 16;
    localparam int LIMIT = 195000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        tx_out;
    logic        use_inj = 1'b0;
    logic        inj_line = 1'b1;
    logic        rx_in;
    int          checks = 0;
    int          errors = 0;

    assign rx_in = use_inj ? inj_line : tx_out;

    always #5 clk = ~clk;

    uart_wordpar #(.CLK_DIV(1)) uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_out(tx_out), .rx_in(rx_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic tx, input logic rx, input logic w9,
                                            input logic pe, input logic po, input logic ie);
        return {26'd0, ie, po, pe, w9, rx, tx};
    endfunction

    function automatic logic [8:0] exp_word(input logic [8:0] v, input logic w9,
                                            input logic pe, input logic po);
        logic [8:0] w;
        w = w9 ? v : {1'b0, v[7:0]};
        if (pe) begin
            if (w9) w[8] = (^w[7:0]) ^ po;
            else    w[7] = (^w[6:0]) ^ po;
        end
        return w;
    endfunction

    task automatic wait_flag(input int bitno, input string req, output logic [31:0] s);
        s = '0;
        for (int i = 0; i < 3000; i++) begin
            bus_read(AS, s);
            if (s[bitno]) break;
        end
        chk(req, {31'd0, s[bitno]}, 32'd1);
    endtask

    task automatic roundtrip(input logic [8:0] v, input logic w9, input logic pe,
                             input logic po, input string req);
        logic [31:0] s, d;
        wait_flag(2, {req, " txe"}, s);
        bus_write(AD, {23'd0, v});
        wait_flag(1, {req, " rxne"}, s);
        chk({req, " perr"}, {31'd0, s[0]}, 32'd0);
        bus_read(AD, d);
        chk(req, d, {23'd0, exp_word(v, w9, pe, po)});
    endtask

    task automatic drive_bits(input logic [8:0] w, input int n);
        @(negedge clk) inj_line = 1'b0;
        repeat (BITC - 1) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) inj_line = w[i];
            repeat (BITC - 1) @(negedge clk);
        end
        @(negedge clk) inj_line = 1'b1;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s, d;
        logic [8:0] v;
        int bad_line;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tx_out", {31'd0, tx_out}, 32'd1);
        bus_read(AS, s); chk("R1 status", s, 32'h4);
        bus_read(AC, s); chk("R1 ctrl", s, 32'h0);

        // R3 frame shape on tx_out, receiver off
        bus_write(AC, mk_ctrl(1, 0, 0, 0, 0, 0));
        bus_write(AD, 32'h1A5);
        for (int i = 0; i < 100 && tx_out; i++) @(negedge clk);
        chk("R3 start edge", {31'd0, tx_out}, 32'd0);
        repeat (BITC / 2) @(negedge clk);
        chk("R3 start bit", {31'd0, tx_out}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            chk("R3 data bit", {31'd0, tx_out}, {31'd0, (8'hA5 >> i) & 8'h1});
        end
        repeat (BITC) @(negedge clk);
        chk("R3 stop bit", {31'd0, tx_out}, 32'd1);
        bus_read(AS, s); chk("R3 txe set", s, 32'h4);

        // R4 exhaustive 8-bit, no parity
        bus_write(AC, mk_ctrl(1, 1, 0, 0, 0, 0));
        for (int i = 0; i < 256; i++) roundtrip(9'(i), 0, 0, 0, "R4");
        bus_read(AS, s); chk("R2 rxne cleared", s, 32'h4);

        // R5 9-bit, no parity
        bus_write(AC, mk_ctrl(1, 1, 1, 0, 0, 0));
        for (int i = 0; i < 64; i++) roundtrip(9'(i * 29 + 3), 1, 0, 0, "R5");

        // R6 R7 parity modes, both lengths
        for (int m = 0; m < 4; m++) begin
            bus_write(AC, mk_ctrl(1, 1, m[1], 1, m[0], 0));
            for (int i = 0; i < 48; i++) roundtrip(9'(i * 37 + m), m[1], 1, m[0], "R6 R7");
        end

        // R8..R11 injected bad parity: 8-bit even, data 0x03 with top bit 1
        bus_write(AC, mk_ctrl(1, 1, 0, 1, 0, 0));
        @(negedge clk) use_inj = 1'b1;
        drive_bits(9'h083, 8);
        repeat (BITC * 2) @(negedge clk);
        chk("R11 irq off when disabled", {31'd0, irq}, 32'd0);
        bus_read(AS, s); chk("R8 perr with rxne", s, 32'h7);
        bus_write(AC, mk_ctrl(1, 1, 0, 1, 0, 1));
        chk("R11 irq on", {31'd0, irq}, 32'd1);
        bus_read(AD, d); chk("R7 parity bit read", d, 32'h083);
        chk("R10 write between cancels", {31'd0, irq}, 32'd1);
        bus_read(AD, d); chk("R10 lone data read", {31'd0, irq}, 32'd1);
        bus_read(AS, s); bus_read(AC, d); bus_read(AD, d);
        chk("R10 other read between", {31'd0, irq}, 32'd1);
        bus_read(AS, s); bus_read(AD, d);
        chk("R9 cleared irq", {31'd0, irq}, 32'd0);
        bus_read(AS, s); chk("R9 status", s, 32'h4);

        // R8 timing: flag appears with the stop bit, not before; 0x01 even is bad
        drive_bits(9'h001, 8);
        repeat (3) @(negedge clk);
        chk("R8 not before stop", {31'd0, irq}, 32'd0);
        repeat (BITC) @(negedge clk);
        chk("R8 set at stop", {31'd0, irq}, 32'd1);
        bus_read(AS, s); chk("R8 status", s, 32'h7);
        bus_read(AD, d); chk("R9 cleared again", {31'd0, irq}, 32'd0);

        // R8 9-bit odd: all zeros is bad, 0x100 is good
        bus_write(AC, mk_ctrl(1, 1, 1, 1, 1, 1));
        drive_bits(9'h100, 9);
        repeat (BITC * 2) @(negedge clk);
        bus_read(AS, s); chk("R8 good 9-bit", s, 32'h6);
        bus_read(AD, d); chk("R7 good 9-bit", d, 32'h100);
        drive_bits(9'h000, 9);
        repeat (BITC * 2) @(negedge clk);
        bus_read(AS, s); chk("R8 bad 9-bit", s, 32'h7);
        bus_read(AD, d); chk("R9 clear 9-bit", {31'd0, irq}, 32'd0);

        // R12 start glitch
        bus_write(AC, mk_ctrl(1, 1, 0, 0, 0, 0));
        @(negedge clk) inj_line = 1'b0;
        repeat (4) @(negedge clk);
        inj_line = 1'b1;
        repeat (BITC * 12) @(negedge clk);
        bus_read(AS, s); chk("R12 glitch ignored", s, 32'h4);
        drive_bits(9'h05A, 8);
        repeat (BITC * 2) @(negedge clk);
        bus_read(AS, s); chk("R12 real frame", s, 32'h6);
        bus_read(AD, d); chk("R12 data", d, 32'h05A);

        // R13 transmit disabled holds the character
        @(negedge clk) use_inj = 1'b0;
        bus_write(AC, mk_ctrl(0, 1, 0, 0, 0, 0));
        bus_write(AD, 32'h0C3);
        bad_line = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!tx_out) bad_line++;
        end
        chk("R13 line idle", bad_line, 0);
        bus_read(AS, s); chk("R13 txe low", s, 32'h0);
        bus_write(AC, mk_ctrl(1, 1, 0, 0, 0, 0));
        wait_flag(1, "R13 sent", s);
        bus_read(AD, d); chk("R13 data", d, 32'h0C3);

        v = 9'h1FF;
        chk("R6 top bit ignored", {23'd0, exp_word(v, 0, 1, 0)}, 32'h0FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule